// File: doc/BRIEF.md
# Activation Lookup Writeback Engine

This block is the second half of a table-driven neuron. A 12-bit two's-complement inner product arrives on a valid-strobed stream. The block uses it, unchanged, as the index into an external activation table that holds a hyperbolic-tangent curve, tanh(0.25·x). The word that comes back from the table is the neuron output. That output is written into a result memory. The writes land in consecutive locations, starting at a base address that is loaded when a run starts.

Software programs a base address and a pattern count, then pulses start. The block accepts exactly that many inputs and performs one write for each of them, a fixed table latency later. When the last write has committed, it raises a done flag, which tells the host that the results region can be read back. Inputs are ignored when no run is armed, once the run's quota has been taken, and in the start cycle itself. A new start abandons any lookups still in flight.

Top module: `act_wb_engine`

## Requirements
- R1: An accepted input drives the table read strobe `tbl_rd_o` high in the same cycle, and `tbl_addr_o` carries the input bits reinterpreted as an unsigned index: -1 gives 0xFFF and -2048 gives 0x800.
- R2: A start pulse loads the write address from `base_addr_i`, and the first write of the run goes to that address.
- R3: Each later write of a run goes to the previous write address plus one, wrapping from 0x3FFFF to 0x00000 in the 18-bit space.
- R4: Every accepted input produces exactly one write. The write comes RD_LAT cycles after the input is accepted, and its data is the table word returned in that cycle. A run never writes more than the programmed pattern count.
- R5: `done_o` rises in the cycle after the write that brings the count of writes to the programmed count, and it stays high until the next start, which clears it. A count of zero raises `done_o` in the cycle after start.
- R6: An input produces no table read and no write in any of these cases: before the first start, after the run has accepted its programmed count, or in a cycle where start is high.
- R7: A start pulse discards every lookup still in flight. None of them produces a write, and the new run writes only its own results, from its own base.
- R8: While reset is applied and right after it, `done_o`, `tbl_rd_o` and `res_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that arms a run and loads base and count |
| base_addr_i | input | ADDR_W (18) | First result address of the run |
| pat_count_i | input | CNT_W (16) | Number of patterns in the run |
| in_valid_i | input | 1 | Inner product valid |
| in_value_i | input | IN_W (12) | Inner product, two's complement |
| tbl_rd_o | output | 1 | Activation table read strobe |
| tbl_addr_o | output | IN_W (12) | Activation table index |
| tbl_data_i | input | OUT_W (12) | Table word, valid RD_LAT cycles after the read |
| res_we_o | output | 1 | Result memory write enable |
| res_addr_o | output | ADDR_W (18) | Result memory write address |
| res_data_o | output | OUT_W (12) | Result memory write data |
| done_o | output | 1 | Run complete, results readable |

## Verification
A wrong write pointer shows up at the first write after start, or on the very next write if the address skips or sticks. A wrong acceptance count or a leaky delay line shows up as a missing write, an extra write or a write in the wrong cycle, at most RD_LAT cycles after the offending input. A completion counter that is off by one moves the rising edge of `done_o` by a cycle relative to the last write. A flush that fails on restart leaves a write at the old run's address within RD_LAT cycles of the start.

// File: rtl/act_wb_pkg.sv
package act_wb_pkg;

    // Phase of the writeback side of a run.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // never started since reset
        PH_RUN  = 2'd1,   // writes outstanding
        PH_DONE = 2'd2    // programmed count committed
    } wb_phase_e;

    // Default geometry shared by the block and its checker.
    localparam int unsigned DEF_IN_W   = 12;
    localparam int unsigned DEF_OUT_W  = 12;
    localparam int unsigned DEF_ADDR_W = 18;
    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_RD_LAT = 1;

endpackage

// File: rtl/act_issue_gate.sv
// Decides which inputs enter the lookup path and counts them against the
// programmed pattern count of the current run.
module act_issue_gate #(
    parameter int unsigned IN_W  = 12,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             valid_i,
    input  logic [IN_W-1:0]  value_i,
    output logic             rd_o,
    output logic [IN_W-1:0]  idx_o
);

    typedef struct packed {
        logic [CNT_W-1:0] issued;
        logic [CNT_W-1:0] limit;
        logic             armed;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  quota_left;
    logic  accept;

    always_comb begin
        gate_d     = gate_q;
        quota_left = (gate_q.issued != gate_q.limit);
        accept     = gate_q.armed && !start_i && valid_i && quota_left;
        if (start_i) begin
            gate_d.issued = '0;
            gate_d.limit  = count_i;
            gate_d.armed  = 1'b1;
        end else if (accept) begin
            gate_d.issued = gate_q.issued + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // The signed value is used bit for bit as the table index.
    assign rd_o  = accept;
    assign idx_o = value_i;

endmodule

// File: rtl/act_valid_pipe.sv
// Delay line that follows a read strobe through the table latency.
// A flush empties every stage at once.
module act_valid_pipe #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic in_i,
    output logic out_o
);

    logic [DEPTH-1:0] stage_d, stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                stage_d = flush_i ? 1'b0 : in_i;
            end
        end else begin : g_chain
            always_comb begin
                if (flush_i) begin
                    stage_d = '0;
                end else begin
                    stage_d = {stage_q[DEPTH-2:0], in_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_o = stage_q[DEPTH-1];

endmodule

// File: rtl/act_writeback.sv
// Owns the result write pointer, the committed-write count and completion.
module act_writeback
    import act_wb_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  written;
        logic [CNT_W-1:0]  limit;
        wb_phase_e         phase;
    } wb_t;

    wb_t              wb_d, wb_q;
    logic [CNT_W-1:0] written_inc;
    logic             last_write;

    assign written_inc = wb_q.written + 1'b1;
    assign last_write  = (written_inc == wb_q.limit);

    always_comb begin
        wb_d = wb_q;
        if (start_i) begin
            wb_d.ptr     = base_i;
            wb_d.written = '0;
            wb_d.limit   = count_i;
            wb_d.phase   = (count_i == '0) ? PH_DONE : PH_RUN;
        end else if (we_i) begin
            // The pointer wraps naturally at ADDR_W bits.
            wb_d.ptr     = wb_q.ptr + 1'b1;
            wb_d.written = written_inc;
            if (last_write) begin
                wb_d.phase = PH_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '{ptr: '0, written: '0, limit: '0, phase: PH_IDLE};
        end else begin
            wb_q <= wb_d;
        end
    end

    assign we_o   = we_i;
    assign addr_o = wb_q.ptr;
    assign data_o = data_i;
    assign done_o = (wb_q.phase == PH_DONE);

endmodule

// File: rtl/act_wb_engine.sv
// Activation lookup followed by auto-incrementing result writeback.
module act_wb_engine
    import act_wb_pkg::*;
#(
    parameter int unsigned IN_W   = DEF_IN_W,
    parameter int unsigned OUT_W  = DEF_OUT_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned RD_LAT = DEF_RD_LAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  pat_count_i,
    input  logic              in_valid_i,
    input  logic [IN_W-1:0]   in_value_i,
    output logic              tbl_rd_o,
    output logic [IN_W-1:0]   tbl_addr_o,
    input  logic [OUT_W-1:0]  tbl_data_i,
    output logic              res_we_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic [OUT_W-1:0]  res_data_o,
    output logic              done_o
);

    localparam int unsigned PIPE_DEPTH = (RD_LAT < 1) ? 1 : RD_LAT;

    logic rd_issue;
    logic rd_landed;

    act_issue_gate #(
        .IN_W (IN_W),
        .CNT_W(CNT_W)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .count_i(pat_count_i),
        .valid_i(in_valid_i),
        .value_i(in_value_i),
        .rd_o   (rd_issue),
        .idx_o  (tbl_addr_o)
    );

    act_valid_pipe #(
        .DEPTH(PIPE_DEPTH)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(start_i),
        .in_i   (rd_issue),
        .out_o  (rd_landed)
    );

    act_writeback #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .DATA_W(OUT_W)
    ) u_wb (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .base_i (base_addr_i),
        .count_i(pat_count_i),
        .we_i   (rd_landed),
        .data_i (tbl_data_i),
        .we_o   (res_we_o),
        .addr_o (res_addr_o),
        .data_o (res_data_o),
        .done_o (done_o)
    );

    assign tbl_rd_o = rd_issue;

endmodule

// File: rtl/act_wb_engine_chk.sv
module act_wb_engine_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic [CNT_W-1:0]  pat_count_i,
    input logic              tbl_rd_o,
    input logic              res_we_o,
    input logic [ADDR_W-1:0] res_addr_o,
    input logic              done_o
);

    // Writes seen since the last start, against the count latched there.
    logic [CNT_W-1:0] wr_seen;
    logic [CNT_W-1:0] lim_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen  <= '0;
            lim_seen <= '0;
        end else if (start_i) begin
            wr_seen  <= '0;
            lim_seen <= pat_count_i;
        end else if (res_we_o) begin
            wr_seen  <= wr_seen + 1'b1;
        end
    end

    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (res_addr_o == $past(base_addr_i)));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we_o && !start_i) |=> (res_addr_o == $past(res_addr_o) + 1'b1));

    p_write_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_o |-> (wr_seen < lim_seen));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    p_no_read_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tbl_rd_o);

    p_no_write_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !res_we_o);

    p_no_read_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !tbl_rd_o);

endmodule

bind act_wb_engine act_wb_engine_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .base_addr_i(base_addr_i),
    .pat_count_i(pat_count_i),
    .tbl_rd_o   (tbl_rd_o),
    .res_we_o   (res_we_o),
    .res_addr_o (res_addr_o),
    .done_o     (done_o)
);

// File: tb/act_wb_engine_tb.sv
module act_wb_engine_tb;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [17:0] base_addr_i = '0;
    logic [15:0] pat_count_i = '0;
    logic        in_valid_i = 1'b0;
    logic [11:0] in_value_i = '0;
    logic        tbl_rd_o;
    logic [11:0] tbl_addr_o;
    logic [11:0] tbl_data_i;
    logic        res_we_o;
    logic [17:0] res_addr_o;
    logic [11:0] res_data_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    act_wb_engine #(.RD_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_addr_i(base_addr_i), .pat_count_i(pat_count_i),
        .in_valid_i(in_valid_i), .in_value_i(in_value_i),
        .tbl_rd_o(tbl_rd_o), .tbl_addr_o(tbl_addr_o), .tbl_data_i(tbl_data_i),
        .res_we_o(res_we_o), .res_addr_o(res_addr_o), .res_data_o(res_data_o),
        .done_o(done_o)
    );

    // Stand-in table contents: any fixed mapping works for checking.
    function automatic logic [11:0] tf(input logic [11:0] a);
        return {a[5:0], a[11:6]} ^ 12'h3C9;
    endfunction

    logic [11:0] tpipe [LAT];
    always @(posedge clk) begin
        tpipe[0] <= tbl_rd_o ? tf(tbl_addr_o) : 12'h000;
        for (int k = 1; k < LAT; k++) tpipe[k] <= tpipe[k-1];
    end
    assign tbl_data_i = tpipe[LAT-1];

    always @(posedge clk) cyc <= cyc + 1;

    // Write log, sampled mid-cycle.
    logic [17:0] wa [64];
    logic [11:0] wd [64];
    int          wc [64];
    logic        wdn [64];
    int          nw = 0;
    int          rise_cyc = -1;
    logic        done_prev = 1'b0;
    always @(negedge clk) begin
        if (res_we_o && nw < 64) begin
            wa[nw] = res_addr_o; wd[nw] = res_data_o; wc[nw] = cyc; wdn[nw] = done_o;
            nw++;
        end
        if (done_o && !done_prev) rise_cyc = cyc;
        done_prev = done_o;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_start(input logic [17:0] b, input logic [15:0] n);
        step(); start_i = 1'b1; base_addr_i = b; pat_count_i = n;
        step(); start_i = 1'b0;
    endtask

    int sc [16];
    logic [11:0] sv [16];

    // Drive one accepted-input slot; checks the table read in that cycle.
    task automatic send(input int i, input logic [11:0] v, input logic expect_rd);
        in_valid_i = 1'b1; in_value_i = v; sc[i] = cyc; sv[i] = v;
        #1;
        chk(tbl_rd_o == expect_rd, expect_rd ? "R1 read strobe" : "R6 read suppressed",
            tbl_rd_o, expect_rd);
        if (expect_rd) chk(tbl_addr_o == v, "R1 table index", tbl_addr_o, v);
        step();
        in_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!done_o && !tbl_rd_o && !res_we_o, "R8 reset outputs",
            {done_o, tbl_rd_o, res_we_o}, 0);
        rst_n = 1'b1;
        step();
        chk(!done_o && !res_we_o, "R8 after reset", {done_o, res_we_o}, 0);
        nw = 0;
        send(0, 12'h123, 1'b0);
        repeat (4) step();
        chk(nw == 0, "R6 no write before first start", nw, 0);
    endtask

    task automatic t_basic();
        logic [11:0] vals [4];
        vals = '{12'h000, 12'h001, 12'hFFF, 12'h800};
        nw = 0;
        do_start(18'h00100, 16'd4);
        for (int i = 0; i < 4; i++) send(i, vals[i], 1'b1);
        repeat (6) step();
        chk(nw == 4, "R4 one write per input", nw, 4);
        for (int i = 0; i < 4; i++) begin
            chk(wa[i] == 18'h00100 + i, i == 0 ? "R2 first address" : "R3 next address",
                wa[i], 18'h00100 + i);
            chk(wd[i] == tf(vals[i]), "R4 write data", wd[i], tf(vals[i]));
            chk(wc[i] == sc[i] + LAT, "R4 write latency", wc[i], sc[i] + LAT);
        end
        chk(wdn[3] == 1'b0, "R5 done low during last write", wdn[3], 0);
        chk(rise_cyc == wc[3] + 1, "R5 done rise cycle", rise_cyc, wc[3] + 1);
        chk(done_o == 1'b1, "R5 done high", done_o, 1);
    endtask

    task automatic t_after_done();
        send(0, 12'h055, 1'b0);
        send(1, 12'h7FF, 1'b0);
        repeat (5) step();
        chk(nw == 4, "R6 no write after done", nw, 4);
        chk(done_o == 1'b1, "R5 done holds", done_o, 1);
    endtask

    task automatic t_wrap();
        nw = 0;
        do_start(18'h3FFFE, 16'd4);
        chk(done_o == 1'b0, "R5 start clears done", done_o, 0);
        for (int i = 0; i < 4; i++) begin
            send(i, 12'(i * 300 + 7), 1'b1);
            step();
        end
        repeat (5) step();
        chk(nw == 4, "R3 wrap write count", nw, 4);
        chk(wa[1] == 18'h3FFFF, "R3 top address", wa[1], 18'h3FFFF);
        chk(wa[2] == 18'h00000, "R3 wrap to zero", wa[2], 0);
        chk(wa[3] == 18'h00001, "R3 after wrap", wa[3], 1);
        chk(wd[3] == tf(sv[3]), "R4 data with gaps", wd[3], tf(sv[3]));
        chk(rise_cyc == wc[3] + 1, "R5 done rise after gaps", rise_cyc, wc[3] + 1);
    endtask

    task automatic t_zero();
        nw = 0;
        do_start(18'h00ABC, 16'd0);
        chk(done_o == 1'b1, "R5 zero count done", done_o, 1);
        send(0, 12'h321, 1'b0);
        repeat (4) step();
        chk(nw == 0, "R6 zero count no write", nw, 0);
    endtask

    task automatic t_restart();
        nw = 0;
        do_start(18'h00200, 16'd5);
        send(0, 12'h0AA, 1'b1);
        // Restart while that lookup is in flight; the valid here is ignored.
        start_i = 1'b1; base_addr_i = 18'h00300; pat_count_i = 16'd2;
        send(1, 12'h0BB, 1'b0);
        start_i = 1'b0;
        send(2, 12'h0CC, 1'b1);
        send(3, 12'h0DD, 1'b1);
        repeat (6) step();
        chk(nw == 2, "R7 only new run writes", nw, 2);
        chk(wa[0] == 18'h00300, "R7 new base", wa[0], 18'h00300);
        chk(wd[0] == tf(12'h0CC), "R7 new data", wd[0], tf(12'h0CC));
        chk(wa[1] == 18'h00301, "R3 restart step", wa[1], 18'h00301);
        chk(done_o == 1'b1, "R5 done after restart", done_o, 1);
    endtask

    initial begin
        step();
        t_reset();
        t_basic();
        t_after_done();
        t_wrap();
        t_zero();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule